// File: doc/BRIEF.md
# Edge-Selectable GPIO Interrupt Controller

This block watches sixteen general-purpose input pins. It turns level changes on them into per-pin pending flags and a single active-low interrupt request. Each pin passes through a two-flop synchronizer. It then passes through an optional glitch filter, built as a per-pin counter. With the filter on, a new level is accepted only after it has held for a fixed number of system clocks.

Each pin has an enable bit, a direction bit, and two edge-select bits. With exactly one select bit set, only that edge is reported. With both select bits set, either edge is reported and the flag stays until the host reads the pin state. With neither select bit set, either edge is reported, but the flag also drops by itself when the pin returns to the level it had at the last state read.

The host signals a read of the low or high state half with a strobe. The strobe clears the pending flags of that half and captures their current filtered levels as the new reference. Register storage and bus access sit outside this block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every status bit is 0 and `irq_n_o` is 1 (released).
- R2: A pin whose direction bit is 0 (output) or whose enable bit is 0 never sets its status bit, whatever its level does.
- R3: With rise-select 1 and fall-select 0, a 0-to-1 change of the filtered level sets the status bit, and a 1-to-0 change does not.
- R4: With rise-select 0 and fall-select 1, only a 1-to-0 change of the filtered level sets the status bit.
- R5: With both select bits 1, either change sets the status bit, and it stays set when the pin returns to its former level, until a state read.
- R6: With both select bits 0, either change away from the reference level sets the status bit. The bit clears without a read once the filtered level equals the reference again. A change that brings the level back to the reference is not an event.
- R7: A one-cycle pulse on `rd_lo_i` clears status bits 7..0 only, and a pulse on `rd_hi_i` clears bits 15..8 only. Each pulse also captures that half's filtered levels as the reference used by R6.
- R8: With the filter bit 1, a new level is accepted only after it has held for FILT_CYCLES (default 32, 640 ns at 50 MHz) consecutive clocks after synchronization. A pulse of 10 clocks (200 ns) never sets a status bit.
- R9: With the filter bit 0, a pin pulse lasting a single clock is enough to set the status bit.
- R10: `irq_n_o` is 0 exactly when at least one status bit is 1.
- R11: When an event and a clearing read of the same half fall in the same cycle, the status bit ends up set.
- R12: With the filter off, a pin change made between clock edges sets its status bit at the fourth rising clock edge after the change: two synchronizer stages, the level register, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Raw pin levels (asynchronous) |
| dir_in_i | input | 16 | Per-pin direction, 1 = input, 0 = output |
| irq_en_i | input | 16 | Per-pin interrupt enable |
| rise_sel_i | input | 16 | Per-pin rising-edge select |
| fall_sel_i | input | 16 | Per-pin falling-edge select |
| filt_en_i | input | 16 | Per-pin glitch filter enable |
| rd_lo_i | input | 1 | One-cycle strobe: host read of state bits 7..0 |
| rd_hi_i | input | 1 | One-cycle strobe: host read of state bits 15..8 |
| status_o | output | 16 | Pending interrupt flag per pin |
| irq_n_o | output | 1 | Interrupt request, 0 = pull line low, 1 = released |

## Verification
The edge decoder is driven with rising, falling and return-to-start sequences under all four select combinations. This separates the edge-only modes from the both-edges mode, which holds its flag, and from the neither mode, which clears itself. In the neither mode, a read taken between changes shows that the reference moves with the read. Pulses of one clock, ten clocks and a sustained level are applied with the filter off and on, which checks the acceptance threshold from both sides. Two pins in opposite halves, a read strobe placed exactly on the event cycle, and an exact latency count check the half split, the event priority and the pipeline depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Event decision for one pin given its edge selects and levels.
  function automatic logic edge_event(input logic rise_sel, input logic fall_sel,
                                      input logic rose, input logic fell,
                                      input logic lvl, input logic ref_lvl);
    if (!rise_sel && !fall_sel)
      return (rose || fell) && (lvl != ref_lvl);
    else
      return (rise_sel && rose) || (fall_sel && fell);
  endfunction

  // Self-clearing condition of the neither-select mode.
  function automatic logic back_to_ref(input logic rise_sel, input logic fall_sel,
                                       input logic lvl, input logic ref_lvl);
    return !rise_sel && !fall_sel && (lvl == ref_lvl);
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
  parameter int FILT_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic filt_en_i,
  output logic lvl_o
);
  localparam int CW = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES - 1);

  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic          differ_w;
  logic          accept_w;

  assign differ_w = raw_i != lvl_q;
  assign accept_w = filt_en_i && differ_w && (cnt_q == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (!filt_en_i) begin
      lvl_q <= raw_i;
      cnt_q <= '0;
    end else if (!differ_w) begin
      cnt_q <= '0;
    end else if (accept_w) begin
      lvl_q <= raw_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  AST_FILT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en_i && !accept_w) |=> $stable(lvl_q)); // R8
  AST_FILT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_en_i && !differ_w) |=> $stable(lvl_q)); // R9
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic dir_in_i,
  input  logic irq_en_i,
  input  logic rise_sel_i,
  input  logic fall_sel_i,
  input  logic rd_i,
  output logic pend_o,
  output logic evt_o
);
  logic lvl_d_q, ref_q, pend_q;
  logic active_w, rose_w, fell_w, evt_w, clr_w;

  assign active_w = irq_en_i && dir_in_i;
  assign rose_w   = lvl_i && !lvl_d_q;
  assign fell_w   = !lvl_i && lvl_d_q;
  assign evt_w    = active_w &&
                    edge_event(rise_sel_i, fall_sel_i, rose_w, fell_w, lvl_i, ref_q);
  assign clr_w    = rd_i ||
                    (active_w && back_to_ref(rise_sel_i, fall_sel_i, lvl_i, ref_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d_q <= 1'b0;
      ref_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      lvl_d_q <= lvl_i;
      if (rd_i) ref_q <= lvl_i;
      if (evt_w)      pend_q <= 1'b1;
      else if (clr_w) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign evt_o  = evt_w;

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_w && !pend_q) |=> !pend_q); // R2
  AST_SET_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !evt_w) |=> !pend_q); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !evt_w) |=> !pend_q); // R7
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_w |=> pend_q); // R11
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (active_w && !rise_sel_i && !fall_sel_i && pend_q && (lvl_i == ref_q) && !evt_w)
      |=> !pend_q); // R6
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] dir_in_i,
  input  logic [NPINS-1:0] irq_en_i,
  input  logic [NPINS-1:0] rise_sel_i,
  input  logic [NPINS-1:0] fall_sel_i,
  input  logic [NPINS-1:0] filt_en_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_n_o
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] sync_w;
  logic [NPINS-1:0] lvl_w;
  logic [NPINS-1:0] pend_w;
  logic [NPINS-1:0] evt_w;

  gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rd_w;
    assign rd_w = (i < HALF) ? rd_lo_i : rd_hi_i;

    gpio_irq_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (sync_w[i]),
      .filt_en_i (filt_en_i[i]),
      .lvl_o     (lvl_w[i])
    );

    gpio_irq_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl_w[i]),
      .dir_in_i   (dir_in_i[i]),
      .irq_en_i   (irq_en_i[i]),
      .rise_sel_i (rise_sel_i[i]),
      .fall_sel_i (fall_sel_i[i]),
      .rd_i       (rd_w),
      .pend_o     (pend_w[i]),
      .evt_o      (evt_w[i])
    );
  end

  assign status_o = pend_w;
  assign irq_n_o  = ~(|pend_w);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_o && !(|evt_w)) |=> irq_n_o); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_w) |=> !irq_n_o); // R10
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin = '0, dir_in = '1, en = '0, rs = '0, fs = '0, fe = '0;
  logic        rd_lo = 1'b0, rd_hi = 1'b0;
  logic [15:0] status;
  logic        irq_n;
  int          nchk = 0, nbad = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_in_i(dir_in), .irq_en_i(en),
    .rise_sel_i(rs), .fall_sel_i(fs), .filt_en_i(fe),
    .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .status_o(status), .irq_n_o(irq_n)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin = '0; rd_lo = 0; rd_hi = 0;
    en = '0; rs = '0; fs = '0; fe = '0; dir_in = '1;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic rd_pulse(input bit hi);
    if (hi) rd_hi = 1'b1; else rd_lo = 1'b1;
    step(1);
    rd_lo = 1'b0; rd_hi = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", status, 16'h0000);
    chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_inactive();
    do_reset();
    en = 16'h0001; rs = 16'h0001; dir_in = 16'hFFFE;
    pin[0] = 1; step(6); pin[0] = 0; step(6);
    chk("R2 output pin", status, 16'h0000);
    en = 16'h0000; dir_in = '1;
    pin[0] = 1; step(6); pin[0] = 0; step(6);
    chk("R2 disabled pin", status, 16'h0000);
    chk("R2 irq_n", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_rise();
    do_reset();
    en = 16'h0001; rs = 16'h0001;
    pin[0] = 1; step(6);
    chk("R3 rise sets", status, 16'h0001);
    chk("R10 irq low", {15'd0, irq_n}, 16'h0000);
    rd_pulse(0);
    pin[0] = 0; step(6);
    chk("R3 fall ignored", status, 16'h0000);
  endtask

  task automatic t_fall();
    do_reset();
    en = 16'h0001; fs = 16'h0001;
    pin[0] = 1; step(6);
    chk("R4 rise ignored", status, 16'h0000);
    pin[0] = 0; step(6);
    chk("R4 fall sets", status, 16'h0001);
  endtask

  task automatic t_both();
    do_reset();
    en = 16'h0001; rs = 16'h0001; fs = 16'h0001;
    pin[0] = 1; step(6); pin[0] = 0; step(6);
    chk("R5 held after return", status, 16'h0001);
    rd_pulse(0); step(1);
    chk("R5 read clears", status, 16'h0000);
    pin[0] = 1; step(6);
    chk("R5 next edge sets", status, 16'h0001);
  endtask

  task automatic t_neither();
    do_reset();
    en = 16'h0001;
    pin[0] = 1; step(6);
    chk("R6 change sets", status, 16'h0001);
    pin[0] = 0; step(6);
    chk("R6 return clears", status, 16'h0000);
    chk("R10 irq released", {15'd0, irq_n}, 16'h0001);
    pin[0] = 1; step(6);
    rd_pulse(0); step(1);
    chk("R7 read clears and captures", status, 16'h0000);
    pin[0] = 0; step(6);
    chk("R6 change from new ref", status, 16'h0001);
    pin[0] = 1; step(6);
    chk("R6 back to new ref clears", status, 16'h0000);
  endtask

  task automatic t_halves();
    do_reset();
    en = 16'h0201; rs = 16'h0201;
    pin = 16'h0201; step(6);
    chk("R7 both pending", status, 16'h0201);
    rd_pulse(0); step(1);
    chk("R7 low read", status, 16'h0200);
    rd_pulse(1); step(1);
    chk("R7 high read", status, 16'h0000);
  endtask

  task automatic t_filter();
    do_reset();
    en = 16'h0001; rs = 16'h0001; fe = '1;
    pin[0] = 1; step(10); pin[0] = 0; step(50);
    chk("R8 short pulse rejected", status, 16'h0000);
    pin[0] = 1; step(30);
    chk("R8 not yet accepted", status, 16'h0000);
    step(10);
    chk("R8 held level accepted", status, 16'h0001);
  endtask

  task automatic t_nofilt();
    do_reset();
    en = 16'h0001; rs = 16'h0001;
    pin[0] = 1; step(1); pin[0] = 0; step(8);
    chk("R9 one-clock pulse", status, 16'h0001);
  endtask

  task automatic t_race();
    do_reset();
    en = 16'h0001; rs = 16'h0001;
    pin[0] = 1; step(3);
    rd_lo = 1'b1; step(1); rd_lo = 1'b0;
    chk("R11 event beats read", status, 16'h0001);
    step(2);
    chk("R11 stays set", status, 16'h0001);
  endtask

  task automatic t_latency();
    do_reset();
    en = 16'h0001; rs = 16'h0001;
    pin[0] = 1; step(3);
    chk("R12 not before edge 4", status, 16'h0000);
    step(1);
    chk("R12 set at edge 4", status, 16'h0001);
  endtask

  initial begin
    #4_000_000;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_inactive();
    t_rise();
    t_fall();
    t_both();
    t_neither();
    t_halves();
    t_filter();
    t_nofilt();
    t_race();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule